// File: doc/BRIEF.md
# Nine-Bit Queue Buffer with Rewind

This block is a single-clock first-in first-out buffer. By default it stores 2048 words of 9 bits. It is controlled by active-low strobes for write, read, rewind and reset. The strobes are sampled on the clock. An operation fires on the first clock edge where a strobe is seen low after being seen high. A strobe that stays low never repeats its operation.

Three active-low flags report how full the buffer is. They are computed from an occupancy counter: empty, more-than-half, and full. A data-valid output stands in for the output drive of a tri-state bus. It is high only while a read strobe that has fetched a word is still held low. At every other time the data output is to be treated as undriven.

Rewind moves the read pointer back to address zero and leaves the write pointer where it is. A block written since reset can therefore be read out again as many times as needed. A read strobe held low on an empty buffer waits, and it picks up the first word written afterwards. A write strobe held low on a full buffer also waits, and it stores its word as soon as a read frees a slot.

Top module: `fifo9_rewind`

## Requirements
- R1: Words are read out in exactly the order they were written. The buffer holds 2**ADDR_W words of DATA_W bits, which is 2048 x 9 by default.
- R2: The flags follow the stored count N. With N = 0, only `empty_n` is low. With 1 <= N <= half the depth, all flags are high. Above half but below full, only `half_n` is low. At full depth, both `full_n` and `half_n` are low.
- R3: If `rst_n` is low at a clock edge, both pointers and the count are cleared. After that edge, `empty_n` = 0, `half_n` = 1, `full_n` = 1 and `dout_en` = 0. Any words stored before the reset cannot be read.
- R4: A write strobe is ignored while the buffer is full, and a read strobe is ignored while it is empty. In both cases the count and the data stay unchanged.
- R5: Rewind sets the read pointer to zero and leaves the write pointer alone. The count becomes the number of words written since reset, and the flags follow that count. This holds as long as the write pointer has not wrapped past address zero a second time.
- R6: Rewind is taken only when both `wr_n` and `rd_n` are sampled high on the same edge. It may be repeated any number of times.
- R7: A read strobe held low on an empty buffer is served one cycle after the next write. It returns that word. Further writes made while the same strobe stays low do not reach the output.
- R8: A write strobe held low on a full buffer stays pending. On the edge where a read takes a word, `full_n` rises for one cycle. On the next edge the pending word is stored and `full_n` falls again.
- R9: `dout_en` is 1 from the edge where a read strobe fetches a word until the edge where `rd_n` is sampled high. `dout` is valid only while `dout_en` is 1.
- R10: An operation fires only on a sampled high-to-low transition. Holding a strobe low for several cycles performs at most one operation.
- R11: A legal read and a legal write on the same edge leave the count, and therefore the flags, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind strobe, active low |
| din | input | DATA_W | Word to store |
| dout | output | DATA_W | Word read out |
| dout_en | output | 1 | High while the output would be driven |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when more than half the depth is stored |
| full_n | output | 1 | Low when every slot is stored |

## Verification
A wrong occupancy count first shows up on the flags, on the clock edge after the operation that corrupted it. The bench therefore compares all three flags after every strobe against a count it derives itself. A read or write pointer that goes astray shows up as a wrong word on the very next read. A rewind that reloads the wrong count shows up on the flags at once, and it shows up again when the block is drained and the last word or the final empty state comes out wrong. A mishandled pending access shows up in three ways: a one-cycle `full_n` pulse that is missing, an extra word, or an early `dout_en`.

// File: rtl/fifo9_pkg.sv
// Package: types shared by the queue buffer modules.
// Assumes: the flags are active low, as they are at the block's edge.
package fifo9_pkg;

    // Occupancy flags, each active low.
    typedef struct packed {
        logic empty_n;
        logic half_n;
        logic full_n;
    } occ_flags_t;

endpackage

// File: rtl/fifo9_strobe_sense.sv
// Module: fifo9_strobe_sense
// Finds the clock edge on which an active-low strobe is first seen low
// after having been seen high.
// Assumes: the strobe is already synchronous to clk. After reset the
// previous value counts as high, so a strobe already held low through
// reset fires once on the first edge after reset.
module fifo9_strobe_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall
);
    logic prev_q;

    // Remember the value sampled on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= strobe_n;
    end

    // A fall is low now after high on the previous edge.
    assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/fifo9_store.sv
// Module: fifo9_store
// Word storage: an inferred register array with one write port and one
// registered read port.
// Assumes: the controller never reads and writes the same address on the
// same edge.
module fifo9_store #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word on a write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Capture the addressed word on a read and hold it until the next read.
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/fifo9_ctrl.sv
// Module: fifo9_ctrl
// Controller: read and write pointers, the occupancy count, waiting
// (flow-through) accesses, rewind, the output-valid state and the flags.
// Assumes: the strobe falls come from fifo9_strobe_sense. wr_low and
// rd_low are the current sampled levels of the strobes.
module fifo9_ctrl
    import fifo9_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fall,
    input  logic              wr_low,
    input  logic              rd_fall,
    input  logic              rd_low,
    input  logic              rt_fall,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic              out_valid,
    output occ_flags_t        flags
);
    localparam logic [ADDR_W:0]   CNT_FULL = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0]   CNT_HALF = CNT_FULL >> 1;
    localparam logic [ADDR_W:0]   CNT_ONE  = 1;
    localparam logic [ADDR_W-1:0] PTR_ONE  = 1;

    logic [ADDR_W:0]   wptr_q;   // counts writes since reset; top bit marks one pass
    logic [ADDR_W-1:0] rptr_q;
    logic [ADDR_W:0]   cnt_q;
    logic              wr_wait_q, rd_wait_q, rd_done_q;
    logic              wr_req, rd_req, wr_go, rd_go, rt_go;
    logic              is_empty, is_full;

    assign is_empty = (cnt_q == '0);
    assign is_full  = (cnt_q == CNT_FULL);

    // A request is a fresh fall, or an earlier fall still waiting with the strobe held.
    always_comb begin
        wr_req = wr_fall | (wr_wait_q & wr_low);
        rd_req = rd_fall | (rd_wait_q & rd_low);
        wr_go  = wr_req & ~is_full;
        rd_go  = rd_req & ~is_empty;
        rt_go  = rt_fall & ~wr_low & ~rd_low;
    end

    // Keep a blocked request waiting while its strobe stays low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_wait_q <= 1'b0;
            rd_wait_q <= 1'b0;
        end else begin
            wr_wait_q <= wr_req & ~wr_go;
            rd_wait_q <= rd_req & ~rd_go;
        end
    end

    // Move the pointers and the count; rewind reloads the count from the writes made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (rt_go) begin
            rptr_q <= '0;
            cnt_q  <= wptr_q[ADDR_W] ? CNT_FULL : wptr_q;
        end else begin
            if (wr_go) wptr_q <= wptr_q + CNT_ONE;
            if (rd_go) rptr_q <= rptr_q + PTR_ONE;
            case ({wr_go, rd_go})
                2'b10:   cnt_q <= cnt_q + CNT_ONE;
                2'b01:   cnt_q <= cnt_q - CNT_ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Output is valid from a served read until its strobe is released.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_done_q <= 1'b0;
        else if (rd_go)  rd_done_q <= 1'b1;
        else if (!rd_low) rd_done_q <= 1'b0;
    end

    // Drive the storage ports and the flags.
    always_comb begin
        we            = wr_go;
        waddr         = wptr_q[ADDR_W-1:0];
        re            = rd_go;
        raddr         = rptr_q;
        out_valid     = rd_done_q;
        flags.empty_n = ~is_empty;
        flags.half_n  = ~(cnt_q > CNT_HALF);
        flags.full_n  = ~is_full;
    end
endmodule

// File: rtl/fifo9_rewind.sv
// Module: fifo9_rewind (top)
// Single-clock first-in first-out buffer with active-low strobes, a
// rewind of the read pointer, and flow-through of held strobes.
// Assumes: all strobes are synchronous to clk. The data output is valid
// only while dout_en is high.
module fifo9_rewind
    import fifo9_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              empty_n,
    output logic              half_n,
    output logic              full_n
);
    localparam int NSTB = 3;

    logic [NSTB-1:0]   stb_n, stb_fall;
    logic              we, re;
    logic [ADDR_W-1:0] waddr, raddr;
    occ_flags_t        flags;

    assign stb_n = {rt_n, rd_n, wr_n};

    // One edge finder for each strobe.
    for (genvar i = 0; i < NSTB; i++) begin : g_stb
        fifo9_strobe_sense u_sense (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (stb_n[i]),
            .fall     (stb_fall[i])
        );
    end

    fifo9_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fall   (stb_fall[0]),
        .wr_low    (~wr_n),
        .rd_fall   (stb_fall[1]),
        .rd_low    (~rd_n),
        .rt_fall   (stb_fall[2]),
        .we        (we),
        .waddr     (waddr),
        .re        (re),
        .raddr     (raddr),
        .out_valid (dout_en),
        .flags     (flags)
    );

    fifo9_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .re    (re),
        .raddr (raddr),
        .rdata (dout)
    );

    assign empty_n = flags.empty_n;
    assign half_n  = flags.half_n;
    assign full_n  = flags.full_n;
endmodule

// File: rtl/fifo9_rewind_chk.sv
// Module: fifo9_rewind_chk
// Temporal checks on the ports of fifo9_rewind. It is attached to the top
// module with bind.
// Assumes: reset is synchronous and active low.
module fifo9_rewind_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_n,
    input logic rd_n,
    input logic rt_n,
    input logic dout_en,
    input logic empty_n,
    input logic half_n,
    input logic full_n
);
    // R3: the edge after a reset shows the cleared state.
    a_r3_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!empty_n && half_n && full_n && !dout_en));

    // R2: full always comes with half-full.
    a_r2_full_has_half: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);

    // R2: empty excludes the other flags.
    a_r2_empty_alone: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> (half_n && full_n));

    // R4: with no read and no rewind, a full buffer stays full.
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && rd_n && rt_n) |=> !full_n);

    // R4: with no write and no rewind, an empty buffer stays empty.
    a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && wr_n && rt_n) |=> !empty_n);

    // R9: the output is valid only when the read strobe was low on the edge before.
    a_r9_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !$past(rd_n));
endmodule

bind fifo9_rewind fifo9_rewind_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rt_n    (rt_n),
    .dout_en (dout_en),
    .empty_n (empty_n),
    .half_n  (half_n),
    .full_n  (full_n)
);

// File: tb/sim_fifo9_rewind.sv
// Bench for fifo9_rewind with an eight-word configuration. A queue model
// supplies every expected word and flag.
module sim_fifo9_rewind;
    localparam int DW = 9;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en, empty_n, half_n, full_n;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] mq[$];
    logic [DW-1:0] hist [16];
    int            nw = 0;

    fifo9_rewind #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_en(dout_en),
        .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Flag check for a count (R2).
    task automatic chk_flags(input string req, input int n);
        chk(req, {29'd0, empty_n, half_n, full_n},
            {29'd0, 1'(n != 0), 1'(!(n > DEPTH/2)), 1'(n != DEPTH)});
    endtask

    function automatic logic [DW-1:0] word(input int k);
        return DW'((k * 37 + 5) % 512);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        nw = 0;
    endtask

    task automatic do_write(input logic [DW-1:0] d, input string req);
        @(negedge clk);
        wr_n = 1'b0; din = d;
        @(negedge clk);
        wr_n = 1'b1;
        if (mq.size() < DEPTH) begin
            mq.push_back(d);
            hist[nw] = d;
            nw++;
        end
        chk_flags(req, mq.size());
    endtask

    task automatic do_read(input string req);
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        if (mq.size() > 0) begin
            chk(req, {31'd0, dout_en}, 32'd1);
            chk(req, {23'd0, dout}, {23'd0, mq.pop_front()});
        end else begin
            chk(req, {31'd0, dout_en}, 32'd0);
        end
        chk_flags(req, mq.size());
        rd_n = 1'b1;
        @(negedge clk);
        chk("R9 valid drops", {31'd0, dout_en}, 32'd0);
    endtask

    task automatic do_rewind(input string req);
        @(negedge clk);
        rt_n = 1'b0;
        @(negedge clk);
        rt_n = 1'b1;
        mq.delete();
        for (int i = 0; i < nw; i++) mq.push_back(hist[i]);
        chk_flags(req, mq.size());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R3: state after reset
        do_reset();
        chk("R3 reset flags", {29'd0, empty_n, half_n, full_n}, 32'b011);
        chk("R3 reset valid", {31'd0, dout_en}, 32'd0);

        // R2 R1: fill every level, then overfill (R4)
        for (int k = 0; k < DEPTH; k++) do_write(word(k), "R2 fill");
        do_write(9'h1AA, "R4 write full");
        do_write(9'h055, "R4 write full");
        for (int k = 0; k < DEPTH; k++) do_read("R1 drain");
        do_read("R4 read empty");
        do_read("R4 read empty");

        // R1: interleaved pattern
        for (int k = 0; k < 5; k++) begin
            do_write(word(20 + 2*k), "R1 mix");
            do_write(word(21 + 2*k), "R1 mix");
            do_read("R1 mix");
        end
        while (mq.size() > 0) do_read("R1 mix drain");

        // R3: reset drops stored words
        do_write(9'h101, "R3 pre");
        do_write(9'h102, "R3 pre");
        do_reset();
        chk_flags("R3 after reset", 0);
        do_read("R3 lost");

        // R5 R6: rewind of a partial block, repeated
        for (int k = 0; k < 6; k++) do_write(word(40 + k), "R5 load");
        for (int k = 0; k < 4; k++) do_read("R5 pre read");
        do_rewind("R5 rewind flags");
        for (int k = 0; k < 6; k++) do_read("R5 reread");
        do_rewind("R6 rewind again");
        do_read("R6 reread");
        do_read("R6 reread");

        // R6: rewind while read strobe is low is ignored
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R6 read", {23'd0, dout}, {23'd0, mq.pop_front()});
        rt_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1; rt_n = 1'b1;
        @(negedge clk);
        chk_flags("R6 rewind ignored", mq.size());
        do_read("R6 continues");

        // R5: rewind after a full pass restores full
        do_reset();
        for (int k = 0; k < DEPTH; k++) do_write(word(60 + k), "R5 full load");
        for (int k = 0; k < DEPTH; k++) do_read("R5 full drain");
        do_rewind("R5 rewind to full");
        for (int k = 0; k < DEPTH; k++) do_read("R5 full reread");

        // R7: read flow-through
        do_reset();
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R7 waiting", {30'd0, dout_en, empty_n}, 32'b00);
        din = 9'h0A5; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        chk("R7 written", {30'd0, dout_en, empty_n}, 32'b01);
        @(negedge clk);
        chk("R7 served", {30'd0, dout_en, empty_n}, 32'b10);
        chk("R7 data", {23'd0, dout}, 32'h0A5);
        din = 9'h15A; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        chk("R7 later write", {23'd0, dout}, 32'h0A5);
        chk("R7 later flags", {31'd0, empty_n}, 32'd1);
        @(negedge clk);
        rd_n = 1'b1;
        mq.push_back(9'h15A);
        @(negedge clk);
        chk("R9 released", {31'd0, dout_en}, 32'd0);
        do_read("R7 next word");

        // R8: write flow-through
        for (int k = 0; k < DEPTH; k++) do_write(word(80 + k), "R8 fill");
        @(negedge clk);
        wr_n = 1'b0; din = 9'h1F0;
        @(negedge clk);
        chk("R8 pending", {31'd0, full_n}, 32'd0);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R8 read data", {23'd0, dout}, {23'd0, mq.pop_front()});
        chk("R8 full lifts", {31'd0, full_n}, 32'd1);
        @(negedge clk);
        chk("R8 full again", {31'd0, full_n}, 32'd0);
        mq.push_back(9'h1F0);
        rd_n = 1'b1; wr_n = 1'b1;
        for (int k = 0; k < DEPTH; k++) do_read("R8 drain");

        // R10: held write strobe stores once
        @(negedge clk);
        wr_n = 1'b0; din = 9'h033;
        @(negedge clk);
        din = 9'h044;
        @(negedge clk);
        din = 9'h055;
        @(negedge clk);
        wr_n = 1'b1;
        mq.push_back(9'h033);
        chk_flags("R10 single write", 1);
        do_read("R10 data");
        do_read("R10 nothing more");

        // R11: simultaneous read and write
        for (int k = 0; k < 3; k++) do_write(word(100 + k), "R11 load");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_n = 1'b0; rd_n = 1'b0; din = word(110 + k);
            @(negedge clk);
            chk("R11 data", {23'd0, dout}, {23'd0, mq.pop_front()});
            mq.push_back(word(110 + k));
            chk_flags("R11 count same", 3);
            wr_n = 1'b1; rd_n = 1'b1;
        end
        while (mq.size() > 0) do_read("R11 drain");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule